// File: doc/BRIEF.md
# SPI Serial Clock Ratio Generator

This block turns a reference clock into the serial clock of an SPI master, using a programmable division ratio. Two encodings of the ratio are offered. The coarse encoding is a power of two from 1 to 32768. The linear encoding joins an 8-bit extension field above a 4-bit coarse field and adds one, which gives any ratio from 1 to 4096. The serial clock keeps an exact 50 percent duty cycle for every ratio. For odd ratios the mid-period transition is placed on the falling edge of the reference, and a ratio of 1 yields a serial clock at the reference frequency.

A shift engine next to the block raises the run enable for the length of a word. While the run enable is low, the serial clock rests at the level set by the polarity input and the divider sits at zero. Each word therefore begins with a full first half period. Two strobes, each one reference cycle wide, mark every transition away from idle (leading) and every transition back to idle (trailing), so the shifter knows when to drive and when to sample. The ratio and the polarity are captured only while the block is idle, which means they cannot change in the middle of a word.

Top module: `spi_ratio_clkgen`

## Requirements
- R1: While reset is asserted and directly after it, sclk is 0 and lead_stb and trail_stb are 0.
- R2: While run_en is low, sclk equals cpol from the second rising reference edge onward, and both strobes are 0. cpol=0 gives an idle-low clock and cpol=1 an idle-high clock.
- R3: With gran_fine=0, one sclk period lasts 2^div_coarse reference cycles, for div_coarse from 0 (ratio 1) to 15 (ratio 32768).
- R4: With gran_fine=1, one sclk period lasts N = {div_ext, div_coarse} + 1 reference cycles. div_ext forms the upper 8 bits and div_coarse the lower 4, so N runs from 1 to 4096.
- R5: The active half of every period (sclk different from cpol) lasts exactly N/2 reference cycles. For odd N, the return to idle falls on a falling reference edge.
- R6: With a ratio of 1, sclk changes level at every reference edge, so its frequency equals the reference frequency.
- R7: The first transition of a word happens at the first rising reference edge at which run_en is sampled high, because the divider restarts from zero for every word.
- R8: lead_stb is high for the one reference cycle that begins at the rising edge where sclk leaves idle. trail_stb is high for the one reference cycle that contains the return to idle: for even N it begins at that rising edge, and for odd N it begins half a cycle before it. With N=1 both strobes stay high while the block runs.
- R9: Changes to div_coarse, div_ext, gran_fine and cpol while run_en is high have no effect on sclk until run_en has gone low.
- R10: When run_en drops, sclk is back at its idle level and both strobes are 0 after the next rising reference edge, even in the middle of a period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ref | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_en | input | 1 | High for the duration of a word |
| div_coarse | input | 4 | Power-of-two exponent, or lower bits of the linear ratio |
| div_ext | input | 8 | Upper bits of the linear ratio |
| gran_fine | input | 1 | 0 selects power-of-two ratio, 1 selects linear ratio |
| cpol | input | 1 | Idle level of sclk |
| sclk | output | 1 | Generated serial clock |
| lead_stb | output | 1 | One-cycle strobe at each transition away from idle |
| trail_stb | output | 1 | One-cycle strobe at each transition back to idle |

## Verification
The bench measures the time of every sclk transition and compares the high time and the period with values computed from the ratio. This exposes a divider that is off by one: it gives N+1 or N-1 cycles. It also exposes an odd ratio split into unequal halves, which a design with no falling-edge stage would produce. The ratios 1, 2, 3, 4096 and 32768 are driven on purpose. Ratio 1 is where a design that only counts rising edges would stall or run at half rate. The two largest ratios are where a counter that is too narrow would wrap. Fields are changed in the middle of a word and cpol is flipped there too; a design that takes its inputs directly would add an edge or shift the period. The delay from run_en to the first edge, and the level after run_en drops in the middle of a period, catch a divider that does not restart and a clock that is left stuck active.

// File: rtl/scr_pkg.sv
`timescale 1ns/1ps
package scr_pkg;

    // Counter width that covers the largest ratio of either encoding.
    function automatic int ratio_width(input int coarse_w, input int ext_w);
        int pow_w;
        int lin_w;
        pow_w = (1 << coarse_w);
        lin_w = coarse_w + ext_w + 1;
        return (pow_w > lin_w) ? pow_w : lin_w;
    endfunction

    typedef enum logic {
        GRAN_POW2   = 1'b0,
        GRAN_LINEAR = 1'b1
    } gran_e;

endpackage

// File: rtl/scr_ratio_decode.sv
`timescale 1ns/1ps
module scr_ratio_decode
    import scr_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int EXT_W    = 8,
    parameter int RATIO_W  = ratio_width(COARSE_W, EXT_W)
) (
    input  logic [COARSE_W-1:0] coarse,
    input  logic [EXT_W-1:0]    ext,
    input  logic                fine,
    output logic [RATIO_W-1:0]  ratio
);
    localparam int PAD_W = RATIO_W - COARSE_W - EXT_W;
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    logic [RATIO_W-1:0] pow_ratio;
    logic [RATIO_W-1:0] lin_ratio;
    gran_e              gran;

    assign gran = gran_e'(fine);

    generate
        if (PAD_W > 0) begin : g_pad
            assign lin_ratio = {{PAD_W{1'b0}}, ext, coarse} + ONE;
        end else begin : g_nopad
            assign lin_ratio = RATIO_W'({ext, coarse}) + ONE;
        end
    endgenerate

    assign pow_ratio = ONE << coarse;

    always_comb begin
        case (gran)
            GRAN_LINEAR: ratio = lin_ratio;
            default:     ratio = pow_ratio;
        endcase
    end
endmodule

// File: rtl/scr_rise_seq.sv
`timescale 1ns/1ps
module scr_rise_seq #(
    parameter int RATIO_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run_en,
    input  logic [RATIO_W-1:0] ratio_in,
    input  logic               pol_in,
    input  logic               fall_lvl,
    output logic               rise_lvl,
    output logic               pol_lvl,
    output logic               half_tog,
    output logic               lead_stb,
    output logic               trail_stb,
    output logic [RATIO_W-1:0] ratio_cur,
    output logic [RATIO_W-1:0] cnt_cur
);
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [RATIO_W-1:0] cnt;
        logic [RATIO_W-1:0] ratio;
        logic               pol;
        logic               lvl;
        logic               half_tog;
        logic               lead;
        logic               trail;
    } seq_t;

    seq_t seq_d;
    seq_t seq_q;
    logic at_lead;
    logic at_mid;
    logic at_last;
    logic odd_ratio;

    always_comb begin
        seq_d     = seq_q;
        at_lead   = (seq_q.cnt == '0);
        at_mid    = (seq_q.cnt == (seq_q.ratio >> 1));
        at_last   = (seq_q.cnt == (seq_q.ratio - ONE));
        odd_ratio = seq_q.ratio[0];
        if (!run_en) begin
            // Idle: capture settings, align both level flops so sclk rests.
            seq_d.cnt      = '0;
            seq_d.ratio    = ratio_in;
            seq_d.pol      = pol_in;
            seq_d.lvl      = fall_lvl;
            seq_d.half_tog = 1'b0;
            seq_d.lead     = 1'b0;
            seq_d.trail    = 1'b0;
        end else begin
            seq_d.lead     = at_lead;
            seq_d.trail    = at_mid;
            seq_d.lvl      = seq_q.lvl ^ at_lead ^ (at_mid & ~odd_ratio);
            seq_d.half_tog = at_mid & odd_ratio;
            seq_d.cnt      = at_last ? '0 : seq_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q       <= '0;
            seq_q.ratio <= ONE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign rise_lvl  = seq_q.lvl;
    assign pol_lvl   = seq_q.pol;
    assign half_tog  = seq_q.half_tog;
    assign lead_stb  = seq_q.lead;
    assign trail_stb = seq_q.trail;
    assign ratio_cur = seq_q.ratio;
    assign cnt_cur   = seq_q.cnt;
endmodule

// File: rtl/scr_fall_toggle.sv
`timescale 1ns/1ps
module scr_fall_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic tog,
    output logic lvl
);
    logic lvl_d;
    logic lvl_q;

    always_comb begin
        lvl_d = lvl_q ^ tog;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
        end else begin
            lvl_q <= lvl_d;
        end
    end

    assign lvl = lvl_q;
endmodule

// File: rtl/spi_ratio_clkgen.sv
`timescale 1ns/1ps
module spi_ratio_clkgen
    import scr_pkg::*;
#(
    parameter int COARSE_W = 4,
    parameter int EXT_W    = 8
) (
    input  logic                clk_ref,
    input  logic                rst_n,
    input  logic                run_en,
    input  logic [COARSE_W-1:0] div_coarse,
    input  logic [EXT_W-1:0]    div_ext,
    input  logic                gran_fine,
    input  logic                cpol,
    output logic                sclk,
    output logic                lead_stb,
    output logic                trail_stb
);
    localparam int RATIO_W = ratio_width(COARSE_W, EXT_W);

    logic [RATIO_W-1:0] ratio_w;
    logic [RATIO_W-1:0] ratio_cur;
    logic [RATIO_W-1:0] cnt_cur;
    logic               rise_lvl;
    logic               fall_lvl;
    logic               pol_lvl;
    logic               half_tog;

    scr_ratio_decode #(
        .COARSE_W (COARSE_W),
        .EXT_W    (EXT_W),
        .RATIO_W  (RATIO_W)
    ) decode_i (
        .coarse (div_coarse),
        .ext    (div_ext),
        .fine   (gran_fine),
        .ratio  (ratio_w)
    );

    scr_rise_seq #(
        .RATIO_W (RATIO_W)
    ) seq_i (
        .clk       (clk_ref),
        .rst_n     (rst_n),
        .run_en    (run_en),
        .ratio_in  (ratio_w),
        .pol_in    (cpol),
        .fall_lvl  (fall_lvl),
        .rise_lvl  (rise_lvl),
        .pol_lvl   (pol_lvl),
        .half_tog  (half_tog),
        .lead_stb  (lead_stb),
        .trail_stb (trail_stb),
        .ratio_cur (ratio_cur),
        .cnt_cur   (cnt_cur)
    );

    scr_fall_toggle fall_i (
        .clk   (clk_ref),
        .rst_n (rst_n),
        .tog   (half_tog),
        .lvl   (fall_lvl)
    );

    // Each transition flips exactly one of the two level flops.
    assign sclk = pol_lvl ^ rise_lvl ^ fall_lvl;
endmodule

// File: rtl/scr_checker.sv
`timescale 1ns/1ps
module scr_checker #(
    parameter int RATIO_W = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               run_en,
    input logic               cpol,
    input logic               sclk,
    input logic               lead_stb,
    input logic               trail_stb,
    input logic [RATIO_W-1:0] ratio,
    input logic [RATIO_W-1:0] cnt
);
    localparam logic [RATIO_W-1:0] ONE = {{(RATIO_W-1){1'b0}}, 1'b1};

    logic [1:0] warm_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            warm_q <= 2'd0;
        end else if (warm_q != 2'd3) begin
            warm_q <= warm_q + 2'd1;
        end
    end

    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !run_en && !$past(run_en) && $stable(cpol)) |-> (sclk == cpol)); // R2

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && !$past(run_en)) |-> (!lead_stb && !trail_stb)); // R10

    AST_START_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd3 && $rose(run_en)) |=> lead_stb); // R7

    AST_LEAD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && lead_stb && ratio > ONE) |=> !lead_stb); // R8

    AST_STROBE_APART: assert property (@(posedge clk) disable iff (!rst_n)
        (trail_stb && ratio > ONE) |-> !lead_stb); // R8

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < ratio); // R3
endmodule

bind spi_ratio_clkgen scr_checker #(.RATIO_W(RATIO_W)) chk_i (
    .clk       (clk_ref),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .cpol      (cpol),
    .sclk      (sclk),
    .lead_stb  (lead_stb),
    .trail_stb (trail_stb),
    .ratio     (ratio_cur),
    .cnt       (cnt_cur)
);

// File: tb/spi_ratio_clkgen_tb_top.sv
`timescale 1ns/1ps
module spi_ratio_clkgen_tb_top;
    logic       clk_ref = 1'b0;
    logic       rst_n = 1'b0;
    logic       run_en = 1'b0;
    logic [3:0] div_coarse = 4'd0;
    logic [7:0] div_ext = 8'd0;
    logic       gran_fine = 1'b0;
    logic       cpol = 1'b0;
    logic       sclk;
    logic       lead_stb;
    logic       trail_stb;

    int  n_checks = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    always #10 clk_ref = ~clk_ref;

    spi_ratio_clkgen dut_i (
        .clk_ref    (clk_ref),
        .rst_n      (rst_n),
        .run_en     (run_en),
        .div_coarse (div_coarse),
        .div_ext    (div_ext),
        .gran_fine  (gran_fine),
        .cpol       (cpol),
        .sclk       (sclk),
        .lead_stb   (lead_stb),
        .trail_stb  (trail_stb)
    );

    function automatic longint exp_ratio(bit fine, logic [3:0] c, logic [7:0] e);
        if (fine) return longint'({e, c}) + 1;
        return longint'(1) << c;
    endfunction

    task automatic chk(bit ok, string req, string what, longint act, longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic setup(bit fine, logic [3:0] c, logic [7:0] e, bit pol);
        @(negedge clk_ref);
        gran_fine = fine; div_coarse = c; div_ext = e; cpol = pol;
        repeat (2) @(negedge clk_ref);
        chk(sclk == pol, "R2", "idle level", sclk, pol);
        chk(!lead_stb && !trail_stb, "R2", "idle strobes", {lead_stb, trail_stb}, 0);
    endtask

    // Run one word, measure three sclk transitions, then stop.
    task automatic run_word(bit disturb, string rq);
        longint n;
        time t0, t1, t2, t3;
        n = exp_ratio(gran_fine, div_coarse, div_ext);
        @(negedge clk_ref);
        run_en = 1'b1; t0 = $time;
        @(sclk); t1 = $time;
        #5;
        chk(lead_stb == 1'b1, "R8", "lead strobe", lead_stb, 1);
        if (disturb) begin
            #5;
            div_coarse = ~div_coarse; gran_fine = ~gran_fine; cpol = ~cpol;
            div_ext = div_ext + 8'd3;
        end
        @(sclk); t2 = $time;
        #5;
        chk(trail_stb == 1'b1, "R8", "trail strobe", trail_stb, 1);
        @(sclk); t3 = $time;
        chk(t1 - t0 == 10, "R7", "first edge delay ns", longint'(t1 - t0), 10);
        chk(t2 - t1 == n * 10, "R5", "active half ns", longint'(t2 - t1), n * 10);
        chk(t3 - t1 == n * 20, rq, "period ns", longint'(t3 - t1), n * 20);
        @(negedge clk_ref);
        run_en = 1'b0;
        @(negedge clk_ref);
        chk(sclk == cpol, "R10", "level after stop", sclk, cpol);
        chk(!lead_stb && !trail_stb, "R10", "strobes after stop", {lead_stb, trail_stb}, 0);
    endtask

    initial begin
        repeat (190000) @(posedge clk_ref);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        repeat (3) @(negedge clk_ref);
        chk(sclk == 1'b0, "R1", "sclk in reset", sclk, 0);
        chk(!lead_stb && !trail_stb, "R1", "strobes in reset", {lead_stb, trail_stb}, 0);
        rst_n = 1'b1;
        @(negedge clk_ref);
        chk(sclk == 1'b0 && !lead_stb && !trail_stb, "R1", "after reset", sclk, 0);

        // Directed corner cases
        setup(1'b0, 4'd0, 8'd0, 1'b0);  run_word(1'b0, "R6");  // ratio 1
        setup(1'b1, 4'd0, 8'd0, 1'b1);  run_word(1'b0, "R6");  // linear ratio 1
        setup(1'b0, 4'd1, 8'd0, 1'b0);  run_word(1'b0, "R3");  // ratio 2
        setup(1'b1, 4'd2, 8'd0, 1'b1);  run_word(1'b0, "R4");  // ratio 3, odd
        setup(1'b1, 4'd4, 8'd0, 1'b0);  run_word(1'b0, "R4");  // ratio 5
        setup(1'b1, 4'd15, 8'hFF, 1'b0); run_word(1'b0, "R4"); // ratio 4096
        setup(1'b0, 4'd15, 8'd0, 1'b1); run_word(1'b0, "R3");  // ratio 32768
        setup(1'b1, 4'd5, 8'd0, 1'b0);  run_word(1'b1, "R9");  // ratio 6, fields changed mid word
        setup(1'b0, 4'd3, 8'd2, 1'b1);  run_word(1'b1, "R9");  // ratio 8, fields changed mid word

        // Constrained random words
        for (int i = 0; i < 14; i++) begin
            bit fine;
            logic [3:0] c;
            logic [7:0] e;
            fine = 1'($urandom % 2);
            c = fine ? 4'($urandom % 16) : 4'($urandom % 10);
            e = 8'($urandom % 4);
            setup(fine, c, e, 1'($urandom % 2));
            run_word(1'b0, fine ? "R4" : "R3");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule